// File: doc/BRIEF.md
# Triple-Copy SECDED Byte Memory

This block is a byte-wide memory that keeps every stored byte three times. A write encodes the byte once into a 13-bit single-error-correcting, double-error-detecting codeword and places that codeword in all three storage arrays at the same address. A read fetches the three codewords together. Each copy is decoded and corrected on its own. The three corrected bytes are then merged by a per-bit two-of-three vote. A multi-bit upset confined to one copy is therefore outvoted, and a single-bit upset is repaired before the vote.

Alongside the voted byte, the block reports for each copy whether a correctable or an uncorrectable error was seen. It also reports whether the three corrected bytes disagree. An error-injection port flips chosen bits of one chosen copy at one chosen address. Test code uses it to create single-bit, multi-bit and cross-copy upsets. The storage arrays are plain synchronous RAMs inside the block. The reset clears only the read registers.

Top module: `tmr_ecc_mem`

## Requirements
- R1: A write stores the same codeword in all three copies. A read of that address returns the written byte one cycle after `rd_en` is sampled, with all flags low.
- R2: Codeword layout: bit 0 is even parity over all 13 bits. Bits 1, 2, 4 and 8 are Hamming checks, where the check at bit 2^k covers every position 1..12 whose index has bit k set. Data bits d0..d7 sit at bits 3, 5, 6, 7, 9, 10, 11 and 12.
- R3: A single flipped bit in one copy is corrected, and that copy's `single_err` bit is set.
- R4: Two flipped bits in one copy set that copy's `double_err` bit. The copy's data is passed on uncorrected, and the vote still returns the written byte.
- R5: `copies_differ` is high exactly when the three corrected bytes are not all equal. This includes upsets that decode with no flag raised.
- R6: For any copy, `single_err` and `double_err` are never both high. A flip of only the parity bit 0 counts as a single error.
- R7: Single-bit upsets in two copies at once are both corrected. The vote is correct and `copies_differ` stays low.
- R8: Identical double-bit data upsets in two copies outvote the clean copy. The output then equals the corrupted byte, both copies show `double_err`, and `copies_differ` is high.
- R9: While `rd_en` is low, `rd_data` and all flags hold their values.
- R10: A synchronous active-low reset sets `rd_data` to 0 and clears all flags. Memory contents survive the reset.
- R11: Injection XORs `inj_mask` into copy `inj_copy` (0..2) at `inj_addr`. A copy index of 3 changes nothing. If a write and an injection hit the same copy and address in one cycle, that copy stores the new codeword XOR the mask.
- R12: A read and a write to the same address in one cycle return the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the read registers |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Byte to store |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| inj_en | input | 1 | Error-injection strobe |
| inj_copy | input | 2 | Target copy of injection (3 = none) |
| inj_addr | input | ADDR_W | Injection address |
| inj_mask | input | 13 | Bits to flip in the stored codeword |
| rd_data | output | 8 | Voted byte |
| single_err | output | 3 | Per-copy corrected-error flag |
| double_err | output | 3 | Per-copy uncorrectable-error flag |
| copies_differ | output | 1 | Corrected copies disagree |

## Verification
The hardest situation to reach from the ports is one where the vote itself is defeated. That needs the same damage in two copies, and each damaged copy must also evade correction. The bench reaches it by injecting the same two-data-bit mask into two copies of one address. It also injects a weight-four mask that leaves the syndrome at zero, which exercises a disagreement with no flag raised. A bench reference model of the arrays, the code and the vote predicts every read.

// File: rtl/tmr_ecc_pkg.sv
// Shared widths and codeword layout for the triple-copy SECDED memory.
// Assumes a fixed 8-bit data word in a 13-bit extended Hamming codeword.
package tmr_ecc_pkg;
    localparam int DATA_W  = 8;
    localparam int CODE_W  = 13;
    localparam int SYN_W   = 4;
    localparam int COPIES  = 3;
    localparam int COPY_W  = 2;
    // Codeword bit positions of data bits d0..d7.
    localparam int DPOS [DATA_W] = '{3, 5, 6, 7, 9, 10, 11, 12};
endpackage

// File: rtl/secded_enc.sv
// SECDED encoder: places the data bits, computes 4 positional checks and the
// overall parity in bit 0. Purely combinational.
module secded_enc
    import tmr_ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);
    // Build the codeword in a local variable, then drive the output.
    always_comb begin
        logic [CODE_W-1:0] v;
        logic p;
        v = '0;
        for (int i = 0; i < DATA_W; i++) v[DPOS[i]] = data_i[i];
        for (int k = 0; k < SYN_W; k++) begin
            p = 1'b0;
            for (int j = 1; j < CODE_W; j++)
                if (((j >> k) & 1) == 1) p = p ^ v[j];
            v[1 << k] = p;
        end
        v[0] = ^v[CODE_W-1:1];
        code_o = v;
    end
endmodule

// File: rtl/secded_dec.sv
// SECDED decoder for one copy: fixes a single error, flags a double error and
// then passes the data through uncorrected. Purely combinational.
module secded_dec
    import tmr_ecc_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [DATA_W-1:0] data_o,
    output logic              single_o,
    output logic              double_o
);
    // Syndrome, overall parity, correction and data extraction.
    always_comb begin
        logic [SYN_W-1:0]  syn;
        logic              odd;
        logic [CODE_W-1:0] fixed;
        syn = '0;
        for (int j = 1; j < CODE_W; j++)
            for (int k = 0; k < SYN_W; k++)
                if (((j >> k) & 1) == 1) syn[k] = syn[k] ^ code_i[j];
        odd   = ^code_i;
        fixed = code_i;
        single_o = odd && (int'(syn) < CODE_W);
        double_o = (!odd && syn != '0) || (odd && int'(syn) >= CODE_W);
        if (single_o && syn != '0) fixed[syn] = ~fixed[syn];
        for (int i = 0; i < DATA_W; i++) data_o[i] = fixed[DPOS[i]];
    end
endmodule

// File: rtl/tmr_vote.sv
// Per-bit two-of-three majority voter; one voter per data bit.
module tmr_vote #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] y_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Majority of the three copies for this bit.
        assign y_o[i] = (a_i[i] & b_i[i]) | (b_i[i] & c_i[i]) | (a_i[i] & c_i[i]);
    end
endmodule

// File: rtl/tmr_ecc_mem.sv
// Triple-copy SECDED byte memory. Each write is encoded once and stored in
// three arrays. Each read decodes every copy, then votes per bit.
// Assumes read-first arrays; reset clears only the read registers.
module tmr_ecc_mem
    import tmr_ecc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              inj_en,
    input  logic [1:0]        inj_copy,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic [12:0]       inj_mask,
    output logic [7:0]        rd_data,
    output logic [2:0]        single_err,
    output logic [2:0]        double_err,
    output logic              copies_differ
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [CODE_W-1:0]              wr_code;
    logic [COPIES-1:0][DATA_W-1:0]  fix_b;

    secded_enc u_enc (.data_i(wr_data), .code_o(wr_code));

    for (genvar g = 0; g < COPIES; g++) begin : g_copy
        logic [CODE_W-1:0] mem [DEPTH];
        logic [CODE_W-1:0] q_code;
        logic              hit;
        logic              same;

        assign hit  = inj_en && (inj_copy == COPY_W'(g));
        assign same = wr_en && (inj_addr == wr_addr);

        // Array update: write, injection, or both merged on one address.
        always_ff @(posedge clk) begin
            if (wr_en)
                mem[wr_addr] <= wr_code ^ ((hit && same) ? inj_mask : '0);
            if (hit && !same)
                mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
        end

        // Read register: captures the raw codeword, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)     q_code <= '0;
            else if (rd_en) q_code <= mem[rd_addr];
        end

        secded_dec u_dec (
            .code_i   (q_code),
            .data_o   (fix_b[g]),
            .single_o (single_err[g]),
            .double_o (double_err[g])
        );
    end

    tmr_vote #(.W(DATA_W)) u_vote (
        .a_i (fix_b[0]),
        .b_i (fix_b[1]),
        .c_i (fix_b[2]),
        .y_o (rd_data)
    );

    assign copies_differ = (fix_b[0] != fix_b[1]) || (fix_b[1] != fix_b[2]);
endmodule

// File: rtl/tmr_ecc_mem_chk.sv
// Assertion checker for tmr_ecc_mem, attached through bind below.
module tmr_ecc_mem_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              inj_en,
    input logic [7:0]        rd_data,
    input logic [2:0]        single_err,
    input logic [2:0]        double_err,
    input logic              copies_differ
);
    // R1: clean write then read returns the byte with no flags.
    a_r1_write_read: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n) && $past(wr_en, 2) && $past(rd_en)
         && $past(rd_addr) == $past(wr_addr, 2)
         && !$past(inj_en, 2) && !$past(inj_en))
        |-> (rd_data == $past(wr_data, 2) && single_err == 3'b000
             && double_err == 3'b000 && !copies_differ));

    // R6: per copy, correctable and uncorrectable flags exclude each other.
    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (single_err & double_err) == 3'b000);

    // R9: outputs hold while no read is issued.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rd_en))
        |-> ($stable(rd_data) && $stable(single_err)
             && $stable(double_err) && $stable(copies_differ)));

    // R10: the cycle after reset, outputs and flags are clear.
    a_r10_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (rd_data == 8'h00 && single_err == 3'b000
                           && double_err == 3'b000 && !copies_differ));
endmodule

bind tmr_ecc_mem tmr_ecc_mem_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_tmr_ecc_mem.sv
// Self-checking bench: vector table, then directed reset and corner tests.
module sim_tmr_ecc_mem;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DEP = 1 << AW;
    localparam int NVEC = 8;
    // {addr[26:23], data[22:15], copy[14:13], mask[12:0]}
    localparam logic [26:0] VEC [NVEC] = '{
        {4'h0, 8'h5A, 2'd3, 13'h0000},   // R1 clean
        {4'h1, 8'hA5, 2'd0, 13'h0008},   // R3 data bit
        {4'h2, 8'h3C, 2'd1, 13'h0001},   // R6 parity bit only
        {4'h3, 8'hC3, 2'd2, 13'h0028},   // R4 double
        {4'h4, 8'hFF, 2'd0, 13'h1FFF},   // R5 miscorrected copy
        {4'h5, 8'h00, 2'd1, 13'h0100},   // R3 check bit
        {4'h6, 8'h81, 2'd2, 13'h1000},   // R3 top bit
        {4'hF, 8'h7E, 2'd0, 13'h0F00}    // R5 undetected copy
    };

    logic clk = 0, rst_n = 0;
    logic wr_en = 0, rd_en = 0, inj_en = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0, inj_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] inj_copy = 2'd3;
    logic [12:0] inj_mask = '0;
    logic [7:0] rd_data;
    logic [2:0] single_err, double_err;
    logic copies_differ;
    int checks = 0, errors = 0;
    logic [12:0] bm [3][DEP];
    logic [7:0] hold_d;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_ecc_mem #(.ADDR_W(AW)) u0 (.*);

    function automatic logic [12:0] m_enc(input logic [7:0] d);
        int pos [8] = '{3, 5, 6, 7, 9, 10, 11, 12};
        logic [12:0] c = '0;
        for (int i = 0; i < 8; i++) c[pos[i]] = d[i];
        for (int p = 1; p <= 8; p = p * 2) begin
            logic s = 0;
            for (int j = 1; j <= 12; j++) if ((j & p) != 0 && j != p) s ^= c[j];
            c[p] = s;
        end
        c[0] = ^c[12:1];
        return c;
    endfunction

    // Returns {single, double, data}.
    function automatic logic [9:0] m_dec(input logic [12:0] c);
        int pos [8] = '{3, 5, 6, 7, 9, 10, 11, 12};
        int syn = 0;
        logic par = ^c;
        logic s, d;
        logic [7:0] o;
        for (int j = 1; j <= 12; j++) if (c[j]) syn = syn ^ j;
        s = par && syn <= 12;
        d = (!par && syn != 0) || (par && syn > 12);
        if (s && syn != 0) c[syn] = ~c[syn];
        for (int i = 0; i < 8; i++) o[i] = c[pos[i]];
        return {s, d, o};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
        for (int k = 0; k < 3; k++) bm[k][a] = m_enc(d);
    endtask

    task automatic do_inject(input logic [1:0] cp, input logic [AW-1:0] a, input logic [12:0] m);
        @(negedge clk); inj_en = 1; inj_copy = cp; inj_addr = a; inj_mask = m;
        @(negedge clk); inj_en = 0; inj_copy = 2'd3;
        if (cp != 2'd3) bm[cp][a] = bm[cp][a] ^ m;
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        @(negedge clk); rd_en = 1; rd_addr = a;
        @(negedge clk); rd_en = 0;
    endtask

    // Compare all outputs with the model's view of address a.
    task automatic read_check(input string req, input logic [AW-1:0] a);
        logic [9:0] r [3];
        logic [7:0] v;
        do_read(a);
        for (int k = 0; k < 3; k++) r[k] = m_dec(bm[k][a]);
        for (int b = 0; b < 8; b++)
            v[b] = (r[0][b] & r[1][b]) | (r[1][b] & r[2][b]) | (r[0][b] & r[2][b]);
        chk({req, " data"}, rd_data, v);
        chk({req, " single"}, single_err, {r[2][9], r[1][9], r[0][9]});
        chk({req, " double"}, double_err, {r[2][8], r[1][8], r[0][8]});
        chk({req, " differ"}, copies_differ,
            (r[0][7:0] != r[1][7:0]) || (r[1][7:0] != r[2][7:0]));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state.
        chk("R10 reset data", rd_data, 8'h00);
        chk("R10 reset flags", {single_err, double_err, copies_differ}, 7'd0);

        // Table walk: R1 R2 R3 R4 R5 R6.
        for (int i = 0; i < NVEC; i++) begin
            do_write(VEC[i][26:23], VEC[i][22:15]);
            if (VEC[i][14:13] != 2'd3) do_inject(VEC[i][14:13], VEC[i][26:23], VEC[i][12:0]);
            read_check($sformatf("R1-table vec%0d", i), VEC[i][26:23]);
        end
        chk("R3 single flag copy0", single_err, 3'b000); // last vec undetected
        chk("R5 undetected differ", copies_differ, 1'b1);

        // R7: single upsets in two copies.
        do_write(4'h8, 8'h99);
        do_inject(2'd0, 4'h8, 13'h0008);
        do_inject(2'd1, 4'h8, 13'h0040);
        read_check("R7", 4'h8);
        chk("R7 voted", rd_data, 8'h99);

        // R8: identical double upsets in two copies defeat the vote.
        do_write(4'h9, 8'h12);
        do_inject(2'd0, 4'h9, 13'h0028);
        do_inject(2'd1, 4'h9, 13'h0028);
        read_check("R8", 4'h9);
        chk("R8 corrupted vote", rd_data, 8'h11);
        chk("R8 double flags", double_err, 3'b011);

        // R9: hold while rd_en low.
        hold_d = rd_data;
        @(negedge clk); rd_addr = 4'h0;
        repeat (3) @(negedge clk);
        chk("R9 hold data", rd_data, hold_d);
        chk("R9 hold flags", double_err, 3'b011);

        // R11: write and inject together; copy index 3 changes nothing.
        @(negedge clk);
        wr_en = 1; wr_addr = 4'hA; wr_data = 8'h44;
        inj_en = 1; inj_copy = 2'd2; inj_addr = 4'hA; inj_mask = 13'h0028;
        @(negedge clk); wr_en = 0; inj_en = 0; inj_copy = 2'd3;
        for (int k = 0; k < 3; k++) bm[k][4'hA] = m_enc(8'h44);
        bm[2][4'hA] = bm[2][4'hA] ^ 13'h0028;
        read_check("R11 merged", 4'hA);
        chk("R11 merged double", double_err, 3'b100);
        do_inject(2'd3, 4'h0, 13'h0008);
        read_check("R11 copy3", 4'h0);
        chk("R11 copy3 flags", single_err, 3'b000);

        // R10: mid-run reset keeps memory.
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        chk("R10 rerun data", rd_data, 8'h00);
        read_check("R10 memory kept", 4'h0);
        chk("R10 memory kept value", rd_data, 8'h5A);

        // R12: same-address read and write return old data.
        @(negedge clk);
        wr_en = 1; wr_addr = 4'h0; wr_data = 8'h77; rd_en = 1; rd_addr = 4'h0;
        @(negedge clk); wr_en = 0; rd_en = 0;
        chk("R12 old data", rd_data, 8'h5A);
        for (int k = 0; k < 3; k++) bm[k][4'h0] = m_enc(8'h77);
        read_check("R12 new", 4'h0);
        chk("R12 new data", rd_data, 8'h77);

        // R2: layout check via a single data-bit flip at bit 12 (d7).
        do_write(4'hB, 8'h00);
        do_inject(2'd0, 4'hB, 13'h1000);
        do_inject(2'd1, 4'hB, 13'h1001);
        do_inject(2'd2, 4'hB, 13'h1001);
        do_read(4'hB);
        chk("R2 d7 at bit12", rd_data, 8'h80);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule